// File: doc/BRIEF.md
# I2C Start/Stop Condition Guard

This block watches the two I2C bus lines and reports every Start condition and every Stop condition it sees. A Start is SDA falling while SCL stays high. A Stop is SDA rising while SCL stays high. Both lines first pass through a reset-to-high synchronizer of `SYNC_STAGES` flops. Each detected condition is then judged against phase flags from the byte engine that sits beside this block. A condition is legitimate when the engine reports that it is idle. It is also legitimate when the engine is a slave receiver waiting for the first bit of a new byte after it has sent an acknowledge. A condition at any other moment is misplaced and raises a bus-error pulse.

The byte engine treats every start or stop pulse as a reset of its transfer state. A slave begins address reception on a Start and returns to idle on a Stop. A misplaced condition in master mode also raises a release request, so that the master lets go of the bus and returns to idle. The error pulse is raised in the same cycle as the condition pulse, so the processor can track the bus state at once.

The qualifier is a Moore machine with seven states. `Q_QUIET` means no condition was seen in the previous cycle. `Q_START_OK` and `Q_STOP_OK` mean a condition arrived in a legal phase. `Q_START_ERR` and `Q_STOP_ERR` mean a misplaced condition arrived while in slave mode. `Q_START_DROP` and `Q_STOP_DROP` mean a misplaced condition arrived while in master mode. Every state moves to its next state on each clock, with one shared choice:
- a detected start goes to one of the three start states, according to the phase;
- a detected stop goes to one of the three stop states, in the same way;
- otherwise the machine returns to `Q_QUIET`.

Each non-quiet state therefore lasts exactly one cycle unless a new condition follows.

Top module: `i2c_cond_guard`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all four outputs are low. The synchronizer and edge history reset to the released-bus level (both lines 1), so lines held high through reset produce no condition.
- R2: When SDA goes from 1 to 0 while SCL is 1 before and after the change, `start_pulse` is high for one cycle. This happens `SYNC_STAGES`+1 clock edges after the edge that first samples the change (3 edges with the default).
- R3: When SDA goes from 0 to 1 while SCL is 1 before and after the change, `stop_pulse` is high for one cycle, with the same latency as R2.
- R4: An SDA change while SCL is 0, or any SCL change while SDA is steady, produces no pulse on any output.
- R5: A condition detected while `eng_idle`=1 produces no bus error and no release request, whatever the other flags are.
- R6: A condition detected while `master_mode`=0 and `slv_rx_boundary`=1 produces no bus error. The boundary flag does not excuse a condition in master mode.
- R7: A condition detected when neither R5 nor R6 applies raises `bus_err_pulse` for one cycle, in the same cycle as its start or stop pulse. The start or stop pulse itself is still given.
- R8: `release_req` is high exactly when `bus_err_pulse` is high and `master_mode` was 1 in the detection cycle. In slave mode `release_req` stays low.
- R9: Every output is a single-cycle pulse. `start_pulse` and `stop_pulse` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| eng_idle | input | 1 | Byte engine is idle |
| slv_rx_boundary | input | 1 | Slave receiver is waiting for the first bit of a byte after its ACK |
| master_mode | input | 1 | Engine is operating as master |
| start_pulse | output | 1 | One-cycle pulse per detected Start |
| stop_pulse | output | 1 | One-cycle pulse per detected Stop |
| bus_err_pulse | output | 1 | One-cycle pulse for a misplaced Start or Stop |
| release_req | output | 1 | One-cycle request for the master to release the bus and idle |

## Verification
The properties assume that the line inputs and phase flags change away from the clock edge and hold steady around each sampling edge. The stimulus therefore changes them only on falling edges. The shape check on a start or stop also assumes that the last four sampled line values come from after reset; a warm-up counter in the checker holds it off until then. The random stimulus changes at most one line per step and holds each setting for four cycles. This keeps SCL high in both samples whenever SDA moves, as the detection rule requires, and lets each pulse end before the next change. Directed steps cover each phase-flag combination that separates a legal condition from a misplaced one.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

    localparam int LINE_COUNT = 2;
    localparam int SCL_IDX    = 1;
    localparam int SDA_IDX    = 0;

    typedef enum logic [2:0] {
        Q_QUIET      = 3'd0,
        Q_START_OK   = 3'd1,
        Q_STOP_OK    = 3'd2,
        Q_START_ERR  = 3'd3,
        Q_STOP_ERR   = 3'd4,
        Q_START_DROP = 3'd5,
        Q_STOP_DROP  = 3'd6
    } q_state_e;

    typedef struct packed {
        logic start;
        logic stop;
    } cond_t;

endpackage

// File: rtl/i2c_cond_sync.sv
module i2c_cond_sync #(
    parameter int              WIDTH   = 2,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] synced
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= raw;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_chain
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= RST_VAL;
            else        stg[g] <= stg[g-1];
        end
    end

    assign synced = stg[STAGES-1];

endmodule

// File: rtl/i2c_cond_edge.sv
module i2c_cond_edge
    import i2c_cond_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  scl_s,
    input  logic  sda_s,
    output cond_t cond
);

    logic scl_prev;
    logic sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    logic scl_held;
    assign scl_held = scl_prev & scl_s;

    always_comb begin
        cond.start = scl_held &  sda_prev & ~sda_s;
        cond.stop  = scl_held & ~sda_prev &  sda_s;
    end

endmodule

// File: rtl/i2c_cond_fsm.sv
module i2c_cond_fsm
    import i2c_cond_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  cond_t cond,
    input  logic  eng_idle,
    input  logic  slv_rx_boundary,
    input  logic  master_mode,
    output logic  start_pulse,
    output logic  stop_pulse,
    output logic  bus_err_pulse,
    output logic  release_req
);

    q_state_e state_q;
    q_state_e state_d;

    logic phase_ok;
    assign phase_ok = eng_idle | (slv_rx_boundary & ~master_mode);

    function automatic q_state_e classify(input cond_t c, input logic ok, input logic mst);
        q_state_e r;
        r = Q_QUIET;
        if (c.start) begin
            if (ok)       r = Q_START_OK;
            else if (mst) r = Q_START_DROP;
            else          r = Q_START_ERR;
        end else if (c.stop) begin
            if (ok)       r = Q_STOP_OK;
            else if (mst) r = Q_STOP_DROP;
            else          r = Q_STOP_ERR;
        end
        return r;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= Q_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = Q_QUIET;
        unique case (state_q)
            Q_QUIET:      state_d = classify(cond, phase_ok, master_mode);
            Q_START_OK:   state_d = classify(cond, phase_ok, master_mode);
            Q_STOP_OK:    state_d = classify(cond, phase_ok, master_mode);
            Q_START_ERR:  state_d = classify(cond, phase_ok, master_mode);
            Q_STOP_ERR:   state_d = classify(cond, phase_ok, master_mode);
            Q_START_DROP: state_d = classify(cond, phase_ok, master_mode);
            Q_STOP_DROP:  state_d = classify(cond, phase_ok, master_mode);
            default:      state_d = Q_QUIET;
        endcase
    end

    always_comb begin
        start_pulse   = 1'b0;
        stop_pulse    = 1'b0;
        bus_err_pulse = 1'b0;
        release_req   = 1'b0;
        unique case (state_q)
            Q_QUIET: ;
            Q_START_OK:  start_pulse = 1'b1;
            Q_STOP_OK:   stop_pulse  = 1'b1;
            Q_START_ERR: begin
                start_pulse   = 1'b1;
                bus_err_pulse = 1'b1;
            end
            Q_STOP_ERR: begin
                stop_pulse    = 1'b1;
                bus_err_pulse = 1'b1;
            end
            Q_START_DROP: begin
                start_pulse   = 1'b1;
                bus_err_pulse = 1'b1;
                release_req   = 1'b1;
            end
            Q_STOP_DROP: begin
                stop_pulse    = 1'b1;
                bus_err_pulse = 1'b1;
                release_req   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/i2c_cond_guard.sv
module i2c_cond_guard
    import i2c_cond_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic eng_idle,
    input  logic slv_rx_boundary,
    input  logic master_mode,
    output logic start_pulse,
    output logic stop_pulse,
    output logic bus_err_pulse,
    output logic release_req
);

    logic [LINE_COUNT-1:0] lines_raw;
    logic [LINE_COUNT-1:0] lines_sync;
    cond_t                 cond;

    always_comb begin
        lines_raw          = '0;
        lines_raw[SCL_IDX] = scl_in;
        lines_raw[SDA_IDX] = sda_in;
    end

    i2c_cond_sync #(
        .WIDTH   (LINE_COUNT),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({LINE_COUNT{1'b1}})
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (lines_raw),
        .synced (lines_sync)
    );

    i2c_cond_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_s (lines_sync[SCL_IDX]),
        .sda_s (lines_sync[SDA_IDX]),
        .cond  (cond)
    );

    i2c_cond_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .cond            (cond),
        .eng_idle        (eng_idle),
        .slv_rx_boundary (slv_rx_boundary),
        .master_mode     (master_mode),
        .start_pulse     (start_pulse),
        .stop_pulse      (stop_pulse),
        .bus_err_pulse   (bus_err_pulse),
        .release_req     (release_req)
    );

endmodule

// File: rtl/i2c_cond_guard_chk.sv
module i2c_cond_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_in,
    input logic sda_in,
    input logic eng_idle,
    input logic slv_rx_boundary,
    input logic master_mode,
    input logic start_pulse,
    input logic stop_pulse,
    input logic bus_err_pulse,
    input logic release_req
);

    // Hold off line-shape checks until four post-reset samples exist.
    logic [2:0] warm;
    logic       ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          warm <= '0;
        else if (warm != 3'd5) warm <= warm + 3'd1;
    end
    assign ready = (warm == 3'd5);

    a_r2_start_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start_pulse) |->
            ($past(sda_in, 4) && !$past(sda_in, 3) && $past(scl_in, 4) && $past(scl_in, 3)));

    a_r3_stop_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && stop_pulse) |->
            (!$past(sda_in, 4) && $past(sda_in, 3) && $past(scl_in, 4) && $past(scl_in, 3)));

    a_r7_error_matches_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse || stop_pulse) |->
            (bus_err_pulse == !$past(eng_idle || (slv_rx_boundary && !master_mode))));

    a_r7_error_needs_cond: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err_pulse |-> (start_pulse || stop_pulse));

    a_r8_release_master_only: assert property (@(posedge clk) disable iff (!rst_n)
        release_req |-> (bus_err_pulse && $past(master_mode)));

    a_r8_release_on_master_err: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err_pulse && $past(master_mode)) |-> release_req);

    a_r9_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);

    a_r9_stop_single: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> !stop_pulse);

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_pulse && stop_pulse));

endmodule

bind i2c_cond_guard i2c_cond_guard_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_in          (scl_in),
    .sda_in          (sda_in),
    .eng_idle        (eng_idle),
    .slv_rx_boundary (slv_rx_boundary),
    .master_mode     (master_mode),
    .start_pulse     (start_pulse),
    .stop_pulse      (stop_pulse),
    .bus_err_pulse   (bus_err_pulse),
    .release_req     (release_req)
);

// File: tb/sim_i2c_cond_guard.sv
`timescale 1ns/1ps
module sim_i2c_cond_guard;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic idle = 1'b1;
    logic bnd = 1'b0;
    logic mst = 1'b0;
    logic st_p, sp_p, err_p, rel_p;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    i2c_cond_guard u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .scl_in          (scl),
        .sda_in          (sda),
        .eng_idle        (idle),
        .slv_rx_boundary (bnd),
        .master_mode     (mst),
        .start_pulse     (st_p),
        .stop_pulse      (sp_p),
        .bus_err_pulse   (err_p),
        .release_req     (rel_p)
    );

    task automatic chk(input string tag, input string name, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %b expected %b at %0t", tag, name, got, exp, $time);
        end
    endtask

    function automatic logic phase_ok(input logic i, input logic b, input logic m);
        return i | (b & ~m);
    endfunction

    // One step: change lines and flags at a falling edge, then check 4 cycles.
    task automatic step(input string tag, input logic n_scl, input logic n_sda,
                        input logic n_idle, input logic n_bnd, input logic n_mst);
        logic e_st, e_sp, e_err, e_rel;
        e_st  = scl && n_scl && sda && !n_sda;
        e_sp  = scl && n_scl && !sda && n_sda;
        e_err = (e_st || e_sp) && !phase_ok(n_idle, n_bnd, n_mst);
        e_rel = e_err && n_mst;
        scl = n_scl; sda = n_sda; idle = n_idle; bnd = n_bnd; mst = n_mst;
        for (int i = 1; i <= 4; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i == 3) begin
                chk(tag, "start_pulse",   st_p,  e_st);
                chk(tag, "stop_pulse",    sp_p,  e_sp);
                chk(tag, "bus_err_pulse", err_p, e_err);
                chk(tag, "release_req",   rel_p, e_rel);
            end else begin
                chk("R9", "start_pulse idle",   st_p,  1'b0);
                chk("R9", "stop_pulse idle",    sp_p,  1'b0);
                chk("R9", "bus_err_pulse idle", err_p, 1'b0);
                chk("R9", "release_req idle",   rel_p, 1'b0);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk("R1", "start_pulse in reset", st_p, 1'b0);
        chk("R1", "bus_err_pulse in reset", err_p, 1'b0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1", "start_pulse after reset", st_p, 1'b0);
        chk("R1", "stop_pulse after reset", sp_p, 1'b0);
        chk("R1", "release_req after reset", rel_p, 1'b0);

        // Directed corner cases.
        step("R2", 1, 0, 1, 0, 0);   // start while idle
        step("R3", 1, 1, 1, 0, 0);   // stop while idle
        step("R4", 0, 1, 0, 0, 1);   // SCL falls
        step("R4", 0, 0, 0, 0, 1);   // SDA moves with SCL low
        step("R4", 0, 1, 0, 0, 0);
        step("R4", 1, 1, 0, 0, 0);   // SCL rises
        step("R5", 1, 0, 1, 1, 1);   // idle excuses master start
        step("R6", 1, 1, 0, 1, 0);   // slave boundary stop
        step("R6", 1, 0, 0, 1, 0);   // slave boundary start
        step("R7", 1, 1, 0, 0, 0);   // misplaced slave stop
        step("R8", 1, 0, 0, 1, 1);   // boundary flag ignored in master mode
        step("R8", 1, 1, 0, 0, 1);   // misplaced master stop
        step("R7", 1, 0, 0, 0, 0);   // misplaced slave start

        // Random walk: one line at most moves per step.
        for (int n = 0; n < 400; n++) begin
            logic ns, nd;
            int   pick;
            ns = scl; nd = sda;
            pick = int'($urandom_range(0, 2));
            if (pick == 0) ns = ~scl;
            else if (pick == 1) nd = ~sda;
            step("R9 random", ns, nd, 1'($urandom_range(0, 3) == 0),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule